// File: doc/BRIEF.md
# Alarm Compare and Interrupt Flag Unit

This unit sits beside a real-time clock's timekeeping core. It watches the current seconds, minutes and hours bytes and three alarm bytes that software has programmed. When the core signals that a once-per-second update has finished, the unit compares all three fields. If every field matches, it raises an alarm flag. A field whose alarm byte has both of its upper two bits set matches any time value, so software can ask for "every second", "every minute" or "every hour" without extra logic.

The unit also holds the interrupt-flag byte. There is one sticky flag each for the periodic tick, the alarm and the update-ended event. Each flag sets on its own event whether or not its source is enabled. A summary bit is high when any pending flag has its enable set. That summary bit also drives the interrupt request line, which is active high.

Software clears all flags by reading the byte, which is signalled here by a one-cycle read strobe. An event that lands in the same cycle as the clearing read is never lost.

Top module: `alarm_irq_unit`

## Requirements
- R1: While reset is asserted and on the first cycle after it, the flag byte reads 0x00 and the interrupt output is low.
- R2: A one-cycle periodic pulse sets flag bit 6 on the next clock edge, whether or not the periodic enable is set.
- R3: A one-cycle update-ended pulse sets flag bit 4 on the next clock edge, whether or not the update enable is set.
- R4: On an update-ended pulse, flag bit 5 is set if all three fields match. A field matches when its alarm byte equals the current time byte. If any single field mismatches, bit 5 is left unchanged.
- R5: An alarm byte whose bits 7 and 6 are both 1 matches any current value of its field.
- R6: The alarm comparison takes effect only on an update-ended pulse. Matching bytes with no pulse leave bit 5 unchanged.
- R7: Flag bit 7 is 1 exactly when at least one of these pairs has both members set: bit 6 with the periodic enable, bit 5 with the alarm enable, or bit 4 with the update enable. The enables act immediately.
- R8: The interrupt output is active high and always equals flag bit 7.
- R9: A read strobe with no coincident event clears bits 6, 5 and 4 on the next clock edge.
- R10: An event in the same cycle as a read strobe leaves its own flag set after that edge. The other flags are cleared.
- R11: Flag bits 3 to 0 always read 0.
- R12: Without a read strobe, a set flag stays set across any number of cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| secNow | input | 8 | Current seconds byte |
| minNow | input | 8 | Current minutes byte |
| hrNow | input | 8 | Current hours byte |
| secAlm | input | 8 | Seconds alarm byte (bits 7:6 = 11 means any) |
| minAlm | input | 8 | Minutes alarm byte (bits 7:6 = 11 means any) |
| hrAlm | input | 8 | Hours alarm byte (bits 7:6 = 11 means any) |
| perEn | input | 1 | Periodic source enable |
| almEn | input | 1 | Alarm source enable |
| updEn | input | 1 | Update-ended source enable |
| perTick | input | 1 | One-cycle periodic event pulse |
| updDone | input | 1 | One-cycle update-ended pulse |
| flagRd | input | 1 | One-cycle strobe: flag byte is being read, clear it |
| flagByte | output | 8 | Flag byte: 7 summary, 6 periodic, 5 alarm, 4 update, 3:0 zero |
| irqOut | output | 1 | Active-high interrupt request |

## Verification
The alarm comparator is driven with exact matches, with one mismatching field at a time, with don't-care alarm bytes, and with matching bytes but no update pulse. Together these separate a missing field from the AND, a wrong don't-care decode, and a compare that ignores the pulse. The random phase biases alarm bytes toward the current time or toward don't-care values, so that real matches happen often. It also toggles the enables on their own, which separates the enable-independent flags from the enable-gated summary bit. Read strobes are placed both alone and on the same cycle as events, which shows whether set beats clear.

// File: rtl/alarm_irq_pkg.sv
package alarm_irq_pkg;

  // Strobes from control to the flag datapath, one per action
  typedef struct packed {
    logic setPer;
    logic setAlm;
    logic setUpd;
    logic clrAll;
  } flagStrobe_t;

  localparam int NUM_SRC = 3;

endpackage

// File: rtl/alarm_irq_ctrl.sv
module alarm_irq_ctrl
  import alarm_irq_pkg::*;
(
  input  logic        perTick,
  input  logic        updDone,
  input  logic        flagRd,
  input  logic        allMatch,
  output flagStrobe_t strobe
);

  // The alarm is sampled only at the once-per-second update boundary
  always_comb begin
    strobe.setPer = perTick;
    strobe.setUpd = updDone;
    strobe.setAlm = updDone & allMatch;
    strobe.clrAll = flagRd;
  end

endmodule

// File: rtl/alarm_irq_dp.sv
module alarm_irq_dp
  import alarm_irq_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int NUM_FIELDS = 3
) (
  input  logic                                clk,
  input  logic                                rstN,
  input  logic [NUM_FIELDS-1:0][DATA_W-1:0]   nowVec,
  input  logic [NUM_FIELDS-1:0][DATA_W-1:0]   almVec,
  input  flagStrobe_t                         strobe,
  input  logic [NUM_SRC-1:0]                  enBits,
  output logic                                allMatch,
  output logic [DATA_W-1:0]                   flagByte,
  output logic                                irqOut
);

  localparam int PAD_W = DATA_W - NUM_SRC - 1;

  logic [NUM_FIELDS-1:0] fieldHit;
  logic [NUM_SRC-1:0]    srcFlags;
  logic [NUM_SRC-1:0]    setVec;
  logic                  anyPend;

  // Per-field comparator; top two bits both set = wildcard
  for (genvar f = 0; f < NUM_FIELDS; f++) begin : g_cmp
    logic wild;
    assign wild        = &almVec[f][DATA_W-1 -: 2];
    assign fieldHit[f] = wild | (almVec[f] == nowVec[f]);
  end
  assign allMatch = &fieldHit;

  // Order: [2]=periodic, [1]=alarm, [0]=update-ended
  assign setVec = {strobe.setPer, strobe.setAlm, strobe.setUpd};

  // Sticky flag bits; an event outranks a same-cycle clear
  for (genvar s = 0; s < NUM_SRC; s++) begin : g_flag
    always_ff @(posedge clk) begin
      if (!rstN) begin
        srcFlags[s] <= 1'b0;
      end else if (setVec[s]) begin
        srcFlags[s] <= 1'b1;
      end else if (strobe.clrAll) begin
        srcFlags[s] <= 1'b0;
      end
    end
  end

  assign anyPend  = |(srcFlags & enBits);
  assign flagByte = {anyPend, srcFlags, {PAD_W{1'b0}}};
  assign irqOut   = anyPend;

  // R9
  clear_takes_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.clrAll && (setVec == '0)) |=> (srcFlags == '0));

  // R12
  flags_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.clrAll && (setVec == '0)) |=> $stable(srcFlags));

  // R10
  set_beats_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.clrAll && strobe.setPer) |=> srcFlags[2]);

  // R8
  irq_needs_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    irqOut |-> (srcFlags != '0));

endmodule

// File: rtl/alarm_irq_unit.sv
module alarm_irq_unit
  import alarm_irq_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] secNow,
  input  logic [DATA_W-1:0] minNow,
  input  logic [DATA_W-1:0] hrNow,
  input  logic [DATA_W-1:0] secAlm,
  input  logic [DATA_W-1:0] minAlm,
  input  logic [DATA_W-1:0] hrAlm,
  input  logic              perEn,
  input  logic              almEn,
  input  logic              updEn,
  input  logic              perTick,
  input  logic              updDone,
  input  logic              flagRd,
  output logic [DATA_W-1:0] flagByte,
  output logic              irqOut
);

  localparam int NUM_FIELDS = 3;

  logic [NUM_FIELDS-1:0][DATA_W-1:0] nowVec;
  logic [NUM_FIELDS-1:0][DATA_W-1:0] almVec;
  logic                              allMatch;
  flagStrobe_t                       strobe;

  assign nowVec = {hrNow, minNow, secNow};
  assign almVec = {hrAlm, minAlm, secAlm};

  alarm_irq_ctrl ctrl_i (
    .perTick  (perTick),
    .updDone  (updDone),
    .flagRd   (flagRd),
    .allMatch (allMatch),
    .strobe   (strobe)
  );

  alarm_irq_dp #(
    .DATA_W     (DATA_W),
    .NUM_FIELDS (NUM_FIELDS)
  ) dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .nowVec   (nowVec),
    .almVec   (almVec),
    .strobe   (strobe),
    .enBits   ({perEn, almEn, updEn}),
    .allMatch (allMatch),
    .flagByte (flagByte),
    .irqOut   (irqOut)
  );

  // R2
  per_sets_chk: assert property (@(posedge clk) disable iff (!rstN)
    perTick |=> flagByte[DATA_W-2]);

  // R3
  upd_sets_chk: assert property (@(posedge clk) disable iff (!rstN)
    updDone |=> flagByte[DATA_W-4]);

  // R6
  alarm_on_update_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(flagByte[DATA_W-3]) |-> $past(updDone));

  // R11
  pad_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    flagByte[DATA_W-5:0] == '0);

endmodule

// File: tb/alarm_irq_unit_tb_top.sv
`timescale 1ns/1ps
module alarm_irq_unit_tb_top;

  logic       clk = 1'b0;
  logic       rstN;
  logic [7:0] secNow, minNow, hrNow, secAlm, minAlm, hrAlm;
  logic       perEn, almEn, updEn, perTick, updDone, flagRd;
  logic [7:0] flagByte;
  logic       irqOut;

  int checks = 0;
  int failures = 0;
  logic [2:0] mFlags;   // model: [2]=periodic [1]=alarm [0]=update
  logic       done = 1'b0;

  always #2.5 clk = ~clk;

  alarm_irq_unit dut_i (
    .clk(clk), .rstN(rstN),
    .secNow(secNow), .minNow(minNow), .hrNow(hrNow),
    .secAlm(secAlm), .minAlm(minAlm), .hrAlm(hrAlm),
    .perEn(perEn), .almEn(almEn), .updEn(updEn),
    .perTick(perTick), .updDone(updDone), .flagRd(flagRd),
    .flagByte(flagByte), .irqOut(irqOut)
  );

  function automatic logic fieldOk(logic [7:0] nowB, logic [7:0] almB);
    return (almB[7:6] == 2'b11) || (almB == nowB);
  endfunction

  function automatic logic [7:0] expByte(logic [2:0] m, logic [2:0] en);
    return {|(m & en), m, 4'h0};
  endfunction

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic clearIns();
    perTick = 0; updDone = 0; flagRd = 0;
  endtask

  // Apply current inputs for one edge, advance model, check after edge
  task automatic step(string tag);
    logic [2:0] setV;
    logic       hit;
    hit  = fieldOk(secNow, secAlm) && fieldOk(minNow, minAlm) && fieldOk(hrNow, hrAlm);
    setV = {perTick, updDone && hit, updDone};
    mFlags = setV | (mFlags & {3{~flagRd}});
    @(posedge clk);
    #1;
    clearIns();
    #0.5;
    check(tag, flagByte, expByte(mFlags, {perEn, almEn, updEn}));
    check("R8", {7'b0, irqOut}, {7'b0, flagByte[7]});
    check("R11", {4'h0, flagByte[3:0]}, 8'h00);
  endtask

  task automatic setTime(logic [7:0] s, logic [7:0] m, logic [7:0] h);
    secNow = s; minNow = m; hrNow = h;
  endtask

  task automatic setAlm(logic [7:0] s, logic [7:0] m, logic [7:0] h);
    secAlm = s; minAlm = m; hrAlm = h;
  endtask

  initial begin
    #(5.0 * 200000);
    failures++;
    $display("FAIL R1 watchdog actual=hung expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    rstN = 0; clearIns();
    perEn = 0; almEn = 0; updEn = 0;
    setTime(8'h00, 8'h00, 8'h00); setAlm(8'h11, 8'h22, 8'h33);
    mFlags = 3'b000;
    repeat (3) @(posedge clk);
    #1;
    // R1: during reset
    check("R1", flagByte, 8'h00);
    check("R1", {7'b0, irqOut}, 8'h00);
    rstN = 1;
    @(posedge clk); #1;
    check("R1", flagByte, 8'h00);

    // R2: periodic with enable off
    perTick = 1; step("R2");
    check("R7", {7'b0, flagByte[7]}, 8'h00);
    // R9: read clears
    flagRd = 1; step("R9");
    // R3: update-ended with alarm mismatch
    setTime(8'h56, 8'h34, 8'h12);
    updDone = 1; step("R3");
    flagRd = 1; step("R9");
    // R6: match without pulse
    setAlm(8'h56, 8'h34, 8'h12);
    repeat (3) step("R6");
    // R4: full match with pulse
    updDone = 1; step("R4");
    flagRd = 1; step("R9");
    // R4: each single field mismatching
    setAlm(8'h57, 8'h34, 8'h12); updDone = 1; step("R4");
    setAlm(8'h56, 8'h35, 8'h12); updDone = 1; step("R4");
    setAlm(8'h56, 8'h34, 8'h13); updDone = 1; step("R4");
    check("R4", {7'b0, flagByte[5]}, 8'h00);
    flagRd = 1; step("R9");
    // R5: wildcards
    setAlm(8'hC0, 8'hFF, 8'hD5); updDone = 1; step("R5");
    check("R5", {7'b0, flagByte[5]}, 8'h01);
    flagRd = 1; step("R9");
    setAlm(8'hC7, 8'h34, 8'h12); setTime(8'h09, 8'h34, 8'h12);
    updDone = 1; step("R5");
    setAlm(8'h80, 8'h34, 8'h12); updDone = 1; flagRd = 1; step("R5");
    check("R5", {7'b0, flagByte[5]}, 8'h00);
    // R7: enables gate only the summary bit
    perTick = 1; step("R2");
    perEn = 0; updEn = 1; #0.5;
    check("R7", flagByte, expByte(mFlags, 3'b001));
    updEn = 0; almEn = 1; #0.5;
    check("R7", flagByte, expByte(mFlags, 3'b010));
    perEn = 1; #0.5;
    check("R7", flagByte, expByte(mFlags, 3'b110));
    // R12: sticky
    repeat (4) step("R12");
    // R10: event with coincident read
    flagRd = 1; perTick = 1; step("R10");
    check("R10", {5'b0, flagByte[6:4]}, 8'h04);
    updDone = 1; step("R3");
    flagRd = 1; updDone = 1; step("R10");

    // Random phase
    for (int i = 0; i < 3000; i++) begin
      int pick;
      setTime(8'($urandom_range(0, 255)), 8'($urandom_range(0, 255)),
              8'($urandom_range(0, 255)));
      pick = $urandom_range(0, 3);
      if (pick == 0)      setAlm(secNow, minNow, hrNow);
      else if (pick == 1) setAlm(8'hC0 | 8'($urandom_range(0, 63)), minNow, hrNow);
      else if (pick == 2) setAlm(secNow, 8'hC0 | 8'($urandom_range(0, 63)),
                                 8'hC0 | 8'($urandom_range(0, 63)));
      else                setAlm(8'($urandom_range(0, 255)), minNow, hrNow);
      perEn   = 1'($urandom_range(0, 1));
      almEn   = 1'($urandom_range(0, 1));
      updEn   = 1'($urandom_range(0, 1));
      perTick = ($urandom_range(0, 3) == 0);
      updDone = ($urandom_range(0, 3) == 0);
      flagRd  = ($urandom_range(0, 4) == 0);
      step("R7");
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule